// File: doc/BRIEF.md
# Mode-Selectable Address/GPIO Port

This block is an 8-bit bidirectional port whose pins act either as general-purpose I/O or as the low byte of an external address bus. A 3-bit operating-mode input decides which. The block holds three byte-wide registers: a direction register, an output data register and an input pull-up enable register. A simple byte bus with a 16-bit address, a write strobe and a combinational read-data output reaches them. The block drives one output value, one output enable and one pull-up enable per pin. It samples the pin levels through a synchronizer. The external address byte comes in on its own input port.

The modes fall into three groups. In modes 1 to 4 the port is a pure address bus. Every pin is driven from the address input and the direction register is locked to all ones. In modes 5 and 6 each pin is either an address output or a plain input, according to its direction bit. In mode 7, and in the reserved mode 0, the port is ordinary GPIO whose outputs come from the data register.

Top module: `addr_port`

## Requirements
- R1: After reset in mode 7, every output enable, output value and pull-up enable is 0, and the data and pull-up registers read 0x00.
- R2: In modes 1 to 4 all eight output enables are 1, and each pin drives the matching bit of the address input. Writes to the direction register at 0xFFC1 have no effect on the pins.
- R3: A read at address 0xFFC1 returns 0xFF in every mode.
- R4: In modes 5 and 6, a pin with direction bit 1 is enabled and drives the matching address-input bit. A pin with direction bit 0 is not enabled and drives 0.
- R5: In modes 7 and 0, a pin with direction bit 1 is enabled and drives the matching data-register bit. A pin with direction bit 0 is not enabled and drives 0.
- R6: A read at 0xFFC3 returns, for each bit, the data-register bit when the pin is an output and the synchronized pin level when it is an input. The direction is all ones in modes 1 to 4.
- R7: The pull-up register at 0xFFD8 reads back what was written. A pin's pull-up enable is 1 only when its pull-up bit is 1, the pin is an input, and the mode is 0, 5, 6 or 7.
- R8: A write takes effect at the first rising clock edge with the strobe high. A write to any other address changes no register, and a read at any other address returns 0x00.
- R9: A pin level change reaches the data read path after exactly two rising clock edges. After one edge the old level is still returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Operating mode 0..7 |
| bus_addr_i | input | 16 | Register bus address (low 16 bits) |
| bus_wdata_i | input | 8 | Register bus write data |
| bus_we_i | input | 1 | Register bus write strobe |
| bus_rdata_o | output | 8 | Register bus read data, combinational from address |
| ext_addr_i | input | 8 | Low address byte from the bus controller |
| pin_in_i | input | 8 | Pin levels from the pads |
| pin_out_o | output | 8 | Per-pin output value |
| pin_oe_o | output | 8 | Per-pin output enable |
| pull_up_o | output | 8 | Per-pin pull-up enable |

## Verification
The hardest case to reach is the locked direction register in modes 1 to 4. Software writes there must leave the pins untouched, even though the same write changes them in other modes. The bench sweeps all eight modes. In each mode it writes several direction, data and pull-up patterns together with varied address and pin inputs. It computes the expected enables, outputs and read values from the mode group. It also checks the two-edge pin synchronizer latency and writes to an undecoded address.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

  typedef enum logic [1:0] {
    MC_ADDR_BUS = 2'd0,
    MC_ADDR_MIX = 2'd1,
    MC_SINGLE   = 2'd2
  } mode_class_e;

  function automatic mode_class_e classify_mode(input logic [2:0] m);
    mode_class_e c;
    case (m)
      3'd1, 3'd2, 3'd3, 3'd4: c = MC_ADDR_BUS;
      3'd5, 3'd6:             c = MC_ADDR_MIX;
      default:                c = MC_SINGLE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/port_sync.sv
`timescale 1ns/1ps
module port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stage_d[s] = d_i;
      end else begin : g_next
        assign stage_d[s] = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/port_regs.sv
`timescale 1ns/1ps
module port_regs
  import gpio_port_pkg::*;
#(
  parameter int                WIDTH    = 8,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 16'hFFC1,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 16'hFFC3,
  parameter logic [ADDR_W-1:0] PUL_ADDR = 16'hFFD8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_class_e       mclass_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  pin_sync_i,
  output logic [WIDTH-1:0]  dir_eff_o,
  output logic [WIDTH-1:0]  dat_o,
  output logic [WIDTH-1:0]  pul_o,
  output logic [WIDTH-1:0]  rdata_o
);
  logic             locked;
  logic             hit_dir, hit_dat, hit_pul;
  logic             dir_en, dat_en, pul_en;
  logic [WIDTH-1:0] dir_q, dir_d;
  logic [WIDTH-1:0] dat_q, dat_d;
  logic [WIDTH-1:0] pul_q, pul_d;

  assign locked  = (mclass_i == MC_ADDR_BUS);
  assign hit_dir = (addr_i == DIR_ADDR);
  assign hit_dat = (addr_i == DAT_ADDR);
  assign hit_pul = (addr_i == PUL_ADDR);

  // next-state and clock enables
  always_comb begin
    dir_en = locked | (we_i & hit_dir);
    dat_en = we_i & hit_dat;
    pul_en = we_i & hit_pul;
    dir_d  = locked ? '1 : wdata_i;
    dat_d  = wdata_i;
    pul_d  = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
      pul_q <= '0;
    end else begin
      if (dir_en) dir_q <= dir_d;
      if (dat_en) dat_q <= dat_d;
      if (pul_en) pul_q <= pul_d;
    end
  end

  assign dir_eff_o = locked ? '1 : dir_q;
  assign dat_o     = dat_q;
  assign pul_o     = pul_q;

  always_comb begin
    if (hit_dir)      rdata_o = '1;
    else if (hit_dat) rdata_o = (dir_eff_o & dat_q) | (~dir_eff_o & pin_sync_i);
    else if (hit_pul) rdata_o = pul_q;
    else              rdata_o = '0;
  end
endmodule

// File: rtl/port_pin_mux.sv
`timescale 1ns/1ps
module port_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  mode_class_e      mclass_i,
  input  logic [WIDTH-1:0] dir_eff_i,
  input  logic [WIDTH-1:0] dat_i,
  input  logic [WIDTH-1:0] pul_i,
  input  logic [WIDTH-1:0] ext_addr_i,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] pu_o
);
  logic use_addr;
  logic pu_allowed;

  assign use_addr   = (mclass_i != MC_SINGLE);
  assign pu_allowed = (mclass_i != MC_ADDR_BUS);

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_pin
      logic src;
      assign src     = use_addr ? ext_addr_i[b] : dat_i[b];
      assign oe_o[b] = dir_eff_i[b];
      assign out_o[b] = dir_eff_i[b] & src;
      assign pu_o[b]  = pu_allowed & pul_i[b] & ~dir_eff_i[b];
    end
  endgenerate
endmodule

// File: rtl/addr_port.sv
`timescale 1ns/1ps
module addr_port
  import gpio_port_pkg::*;
#(
  parameter int                WIDTH       = 8,
  parameter int                ADDR_W      = 16,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DIR_ADDR    = 16'hFFC1,
  parameter logic [ADDR_W-1:0] DAT_ADDR    = 16'hFFC3,
  parameter logic [ADDR_W-1:0] PUL_ADDR    = 16'hFFD8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WIDTH-1:0]  bus_wdata_i,
  input  logic              bus_we_i,
  output logic [WIDTH-1:0]  bus_rdata_o,
  input  logic [WIDTH-1:0]  ext_addr_i,
  input  logic [WIDTH-1:0]  pin_in_i,
  output logic [WIDTH-1:0]  pin_out_o,
  output logic [WIDTH-1:0]  pin_oe_o,
  output logic [WIDTH-1:0]  pull_up_o
);
  mode_class_e      mclass;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] dir_eff, dat, pul;

  assign mclass = classify_mode(mode_i);

  port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_in_i),
    .q_o   (pin_sync)
  );

  port_regs #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W),
    .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR), .PUL_ADDR(PUL_ADDR)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .mclass_i   (mclass),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .we_i       (bus_we_i),
    .pin_sync_i (pin_sync),
    .dir_eff_o  (dir_eff),
    .dat_o      (dat),
    .pul_o      (pul),
    .rdata_o    (bus_rdata_o)
  );

  port_pin_mux #(.WIDTH(WIDTH)) u_mux (
    .mclass_i   (mclass),
    .dir_eff_i  (dir_eff),
    .dat_i      (dat),
    .pul_i      (pul),
    .ext_addr_i (ext_addr_i),
    .out_o      (pin_out_o),
    .oe_o       (pin_oe_o),
    .pu_o       (pull_up_o)
  );
endmodule

// File: rtl/addr_port_chk.sv
`timescale 1ns/1ps
module addr_port_chk #(
  parameter int                WIDTH    = 8,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 16'hFFC1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [WIDTH-1:0]  bus_rdata_o,
  input logic [WIDTH-1:0]  ext_addr_i,
  input logic [WIDTH-1:0]  pin_out_o,
  input logic [WIDTH-1:0]  pin_oe_o,
  input logic [WIDTH-1:0]  pull_up_o
);
  p_locked_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i >= 3'd1 && mode_i <= 3'd4) |-> (pin_oe_o == '1 && pin_out_o == ext_addr_i));

  p_dir_reads_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == DIR_ADDR) |-> (bus_rdata_o == '1));

  p_mix_follows_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd5 || mode_i == 3'd6) |-> (pin_out_o == (ext_addr_i & pin_oe_o)));

  p_out_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out_o & ~pin_oe_o) == '0);

  p_pullup_input_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_up_o & pin_oe_o) == '0);
endmodule

bind addr_port addr_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .ext_addr_i  (ext_addr_i),
  .pin_out_o   (pin_out_o),
  .pin_oe_o    (pin_oe_o),
  .pull_up_o   (pull_up_o)
);

// File: tb/addr_port_tb.sv
`timescale 1ns/1ps
module addr_port_tb;
  localparam logic [15:0] A_DIR = 16'hFFC1;
  localparam logic [15:0] A_DAT = 16'hFFC3;
  localparam logic [15:0] A_PUL = 16'hFFD8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'd7;
  logic [15:0] baddr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic        we = 1'b0;
  logic [7:0]  rdata, ext_addr = 8'h00, pin_in = 8'h00;
  logic [7:0]  pout, poe, pu;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  addr_port u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .bus_addr_i(baddr),
    .bus_wdata_i(wdata), .bus_we_i(we), .bus_rdata_o(rdata),
    .ext_addr_i(ext_addr), .pin_in_i(pin_in),
    .pin_out_o(pout), .pin_oe_o(poe), .pull_up_o(pu)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    baddr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    baddr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic do_reset(input logic [2:0] m);
    @(negedge clk);
    mode = m; rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] pats [6];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
    pats[3] = 8'h5A; pats[4] = 8'h0F; pats[5] = 8'h81;

    // R1 reset state in mode 7
    do_reset(3'd7);
    @(negedge clk);
    #0.5;
    check("R1 oe", poe, 8'h00);
    check("R1 out", pout, 8'h00);
    check("R1 pu", pu, 8'h00);
    bus_read(A_PUL, r); check("R1 pul read", r, 8'h00);
    bus_write(A_DIR, 8'hFF);
    bus_read(A_DAT, r); check("R1 dat read", r, 8'h00);

    // R8 write timing: no change before the edge, change after it
    @(negedge clk);
    baddr = A_DIR; wdata = 8'h3C; we = 1'b1;
    #0.5; check("R8 before edge", poe, 8'hFF);
    @(negedge clk); we = 1'b0;
    #0.5; check("R8 after edge", poe, 8'h3C);

    // R8 undecoded address
    bus_write(A_DAT, 8'h11);
    bus_write(A_PUL, 8'h22);
    bus_write(16'hFFC2, 8'h77);
    bus_write(16'h00C1, 8'h77);
    bus_read(16'hFFC2, r); check("R8 undecoded read", r, 8'h00);
    bus_read(A_PUL, r); check("R8 pul kept", r, 8'h22);
    check("R8 dir kept", poe, 8'h3C);
    bus_write(A_DIR, 8'hFF);
    bus_read(A_DAT, r); check("R8 dat kept", r, 8'h11);

    // R9 synchronizer latency: pins are inputs
    bus_write(A_DIR, 8'h00);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'hC9;
    @(negedge clk);
    bus_read(A_DAT, r); check("R9 one edge old", r, 8'h00);
    @(negedge clk);
    bus_read(A_DAT, r); check("R9 two edges new", r, 8'hC9);

    // sweep all modes and several patterns
    for (int m = 0; m < 8; m++) begin
      do_reset(m[2:0]);
      for (int p = 0; p < 6; p++) begin
        logic [7:0] pat, dat, pul, ea, pin, dire, src, exp_pu;
        bit locked, mix;
        pat = pats[p];
        dat = ~pat ^ m[7:0];
        pul = pat ^ 8'h3C;
        ea  = pat + 8'(m * 17);
        pin = pat ^ 8'hC3;
        locked = (m >= 1 && m <= 4);
        mix    = (m == 5 || m == 6);
        bus_write(A_DIR, pat);
        bus_write(A_DAT, dat);
        bus_write(A_PUL, pul);
        ext_addr = ea;
        pin_in = pin;
        repeat (3) @(negedge clk);
        dire = locked ? 8'hFF : pat;
        src  = (locked || mix) ? ea : dat;
        exp_pu = locked ? 8'h00 : (pul & ~dire);
        #0.5;
        if (locked) begin
          check("R2 oe locked", poe, 8'hFF);
          check("R2 out address", pout, ea);
        end else if (mix) begin
          check("R4 oe", poe, dire);
          check("R4 out address", pout, dire & ea);
        end else begin
          check("R5 oe", poe, dire);
          check("R5 out data", pout, dire & dat);
        end
        check("R7 pull-up enable", pu, exp_pu);
        bus_read(A_DIR, r); check("R3 dir read", r, 8'hFF);
        bus_read(A_DAT, r); check("R6 dat read", r, (dire & dat) | (~dire & pin));
        bus_read(A_PUL, r); check("R7 pul read", r, pul);
        check("R8 src sanity", pout & ~poe, 8'h00);
        if (src == 8'h00) check("R5 zero source", pout, 8'h00);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule